// File: doc/BRIEF.md
# Sticky Per-Word Fuse Access Lock Banks

This block holds the access locks for a shadowed fuse array. Every fuse word has three independent lock bits. The first is a refresh lock, which stops a shadow-read command from reloading that word's shadow copy. The second is a shadow-update lock, which stops bus writes from reaching the shadow copy. The third is a burn lock, which stops program commands to the word. Software sets lock bits through a simple register port. A bit can be set but not cleared, and it stays set until the next reset.

The command controller and the shadow register file ask the block about one word index each. The block answers each of them through a separate combinational gate output in the same cycle. The block also holds a debug-enable value of `DBG_W` bits and drives it to the debug logic. A sticky freeze bit can make that value read-only until reset.

Register map (byte addresses; bits [1:0] of the address are ignored):
- Refresh locks at 0x00.
- Shadow-update locks at 0x20.
- Burn locks at 0x40.
- Debug enable at 0x60.
- Freeze control at 0x64.

Within each lock kind, bank n sits at the kind base plus 4*n.

Top module: `fuse_lock_banks`

## Requirements
- R1: After reset, every lock bit, the debug-enable value and the freeze bit are 0. All gate outputs report unblocked for in-range word ids, and every register reads 0.
- R2: Word id `w` maps to bank `w>>5` and to bit `w & 31` of that bank. The bank's byte address is the kind base plus `4*(w>>5)`. The kind bases are 0x00 for refresh, 0x20 for shadow-update and 0x40 for burn.
- R3: A write to a lock bank ORs the write data into that bank. Data bits that are 0 change nothing. Lock bits are never cleared except by reset.
- R4: `rd_blocked` equals the refresh lock bit of word `rd_idx`. It is combinational and valid in the same cycle.
- R5: `sw_blocked` equals the shadow-update lock bit of word `sw_idx`. It is combinational.
- R6: `pg_blocked` equals the burn lock bit of word `pg_idx`. It is combinational.
- R7: A write to 0x60 stores write-data bits [10:0] only. Reading 0x60 returns that value zero-extended, and `dbg_en` drives the same value.
- R8: Writing 1 to bit 0 of 0x64 sets the freeze bit, which reads back at bit 0 of 0x64. Writing 0 there has no effect. While the freeze bit is 1, writes to 0x60 are ignored.
- R9: Bank slots that have no words behind them read 0 and cannot be set. This covers slots at or past bank `ceil(NUM_WORDS/32)` in a kind's 8-slot window, and bits for ids at or above `NUM_WORDS`. A gate query for an id at or above `NUM_WORDS` reports blocked.
- R10: Addresses outside the map read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data at `reg_addr` |
| rd_idx | input | IDX_W | Word id queried by the shadow-read command |
| rd_blocked | output | 1 | Refresh lock of `rd_idx` |
| sw_idx | input | IDX_W | Word id targeted by a shadow bus write |
| sw_blocked | output | 1 | Shadow-update lock of `sw_idx` |
| pg_idx | input | IDX_W | Word id targeted by a program command |
| pg_blocked | output | 1 | Burn lock of `pg_idx` |
| dbg_en | output | DBG_W | Debug-enable value |

## Verification
Three properties are checked by assertions on every cycle:
- no lock bit ever falls while reset is high, and a bank holds its value when no write hits it;
- the freeze bit never clears, and a frozen debug value stays put under writes;
- an out-of-range query always reports blocked.

The bench's scenarios are needed to show the remaining behaviour:
- that ids reach the correct bank and bit;
- that each gate follows its own kind and not another kind;
- that the 11-bit masking holds;
- that unmapped and empty bank slots stay inert.

The bench compares randomized mixes of writes, readbacks and gate queries against a reference model.

// File: rtl/fuse_lock_pkg.sv
// Package: shared constants and helpers for the fuse lock banks.
// Assumes 32-bit register data and a fixed 8-word window per lock kind.
package fuse_lock_pkg;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned BIT_SEL_W  = 5;   // bit within a 32-bit bank
    localparam int unsigned SPAN_W     = 3;   // 8 bank slots per kind
    localparam int unsigned NUM_KINDS  = 3;
    localparam int unsigned DBG_WORD   = 24;  // byte 0x60
    localparam int unsigned CTRL_WORD  = 25;  // byte 0x64

    typedef enum logic [1:0] {
        KIND_REFRESH = 2'd0,
        KIND_SHADOW  = 2'd1,
        KIND_BURN    = 2'd2
    } lock_kind_e;

    // Mask of bits in bank b that correspond to real words (id < n).
    function automatic logic [DATA_W-1:0] bank_mask(int unsigned b, int unsigned n);
        logic [DATA_W-1:0] m;
        for (int unsigned i = 0; i < DATA_W; i++) begin
            m[i] = ((b * DATA_W + i) < n);
        end
        return m;
    endfunction
endpackage

// File: rtl/lock_bank_set.sv
// Module: one lock kind - a set of write-one-to-set 32-bit banks.
// Does: ORs bus writes into the selected bank, provides bank readback and a
// combinational per-word lock query. Assumes NUM_WORDS > 32 and that the
// bank count fits in the 2**SEL_W slot window.
module lock_bank_set
    import fuse_lock_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 96,
    parameter int unsigned SEL_W     = 3,
    parameter int unsigned IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_bank,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_bank,
    output logic [DATA_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  q_idx,
    output logic              q_blocked
);
    localparam int unsigned NUM_BANKS = (NUM_WORDS + DATA_W - 1) / DATA_W;
    localparam int unsigned BANK_W    = IDX_W - BIT_SEL_W;

    logic [DATA_W-1:0] bank_q [NUM_BANKS];

    logic [BANK_W-1:0]    q_bank;
    logic [BIT_SEL_W-1:0] q_bit;
    logic                 q_out_of_range;

    assign q_bank         = q_idx[IDX_W-1:BIT_SEL_W];
    assign q_bit          = q_idx[BIT_SEL_W-1:0];
    assign q_out_of_range = ({1'b0, q_idx} >= (IDX_W+1)'(NUM_WORDS));

    // Purpose: sticky set of lock bits in the addressed bank, cleared by reset.
    always_ff @(posedge clk) begin
        for (int unsigned b = 0; b < NUM_BANKS; b++) begin
            if (!rst_n) begin
                bank_q[b] <= '0;
            end else if (wr_en && (wr_bank == SEL_W'(b))) begin
                bank_q[b] <= bank_q[b] | (wr_data & bank_mask(b, NUM_WORDS));
            end
        end
    end

    // Purpose: bank readback; empty slots read zero.
    always_comb begin
        rd_data = '0;
        for (int unsigned b = 0; b < NUM_BANKS; b++) begin
            if (rd_bank == SEL_W'(b)) rd_data = bank_q[b];
        end
    end

    // Purpose: per-word lock query; ids past the array report blocked.
    always_comb begin
        q_blocked = 1'b1;
        for (int unsigned b = 0; b < NUM_BANKS; b++) begin
            if (q_bank == BANK_W'(b)) q_blocked = bank_q[b][q_bit];
        end
        if (q_out_of_range) q_blocked = 1'b1;
    end

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank_chk
            // R3
            lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> ((bank_q[g] & $past(bank_q[g])) == $past(bank_q[g])));
            // R3
            lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && (wr_bank == SEL_W'(g))) |=> $stable(bank_q[g]));
            // R9
            lock_empty_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bank_q[g] & ~bank_mask(g, NUM_WORDS)) == '0);
        end
    endgenerate

    // R9
    range_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_out_of_range |-> q_blocked);
endmodule

// File: rtl/dbg_enable_reg.sv
// Module: debug-enable register with a sticky freeze bit.
// Does: stores the low DBG_W bits of a write unless frozen; the freeze bit is
// write-one-to-set and clears only on reset.
module dbg_enable_reg #(
    parameter int unsigned DBG_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbg_wr,
    input  logic [DBG_W-1:0] dbg_wdata,
    input  logic             frz_wr,
    input  logic             frz_set,
    output logic [DBG_W-1:0] dbg_q,
    output logic             frozen_q
);
    // Purpose: capture the masked debug value while not frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_q <= '0;
        end else if (dbg_wr && !frozen_q) begin
            dbg_q <= dbg_wdata;
        end
    end

    // Purpose: sticky freeze bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frozen_q <= 1'b0;
        end else if (frz_wr && frz_set) begin
            frozen_q <= 1'b1;
        end
    end

    // R8
    freeze_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen_q |=> frozen_q);
    // R8
    frozen_dbg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen_q |=> $stable(dbg_q));
    // R7
    dbg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_wr && !frozen_q) |=> (dbg_q == $past(dbg_wdata)));
endmodule

// File: rtl/fuse_lock_banks.sv
// Module: top of the fuse access lock block.
// Does: decodes the register port into three lock kinds, the debug-enable
// register and the freeze control; drives one combinational gate per kind.
// Assumes a single-cycle write strobe and combinational reads.
module fuse_lock_banks
    import fuse_lock_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 96,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DBG_W     = 11,
    parameter int unsigned IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_blocked,
    input  logic [IDX_W-1:0]  sw_idx,
    output logic              sw_blocked,
    input  logic [IDX_W-1:0]  pg_idx,
    output logic              pg_blocked,
    output logic [DBG_W-1:0]  dbg_en
);
    localparam int unsigned WADDR_W = ADDR_W - 2;
    localparam int unsigned REGN_W  = WADDR_W - SPAN_W;

    logic [WADDR_W-1:0] word_addr;
    logic [REGN_W-1:0]  region;
    logic [SPAN_W-1:0]  slot;
    logic [1:0]         unused_addr_lsb;

    assign word_addr       = reg_addr[ADDR_W-1:2];
    assign region          = word_addr[WADDR_W-1:SPAN_W];
    assign slot            = word_addr[SPAN_W-1:0];
    assign unused_addr_lsb = reg_addr[1:0];

    logic [IDX_W-1:0]  kind_idx     [NUM_KINDS];
    logic              kind_blocked [NUM_KINDS];
    logic [DATA_W-1:0] kind_rdata   [NUM_KINDS];

    assign kind_idx[KIND_REFRESH] = rd_idx;
    assign kind_idx[KIND_SHADOW]  = sw_idx;
    assign kind_idx[KIND_BURN]    = pg_idx;
    assign rd_blocked = kind_blocked[KIND_REFRESH];
    assign sw_blocked = kind_blocked[KIND_SHADOW];
    assign pg_blocked = kind_blocked[KIND_BURN];

    generate
        for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
            logic kind_wr;
            assign kind_wr = reg_wr && (region == REGN_W'(k));

            lock_bank_set #(
                .NUM_WORDS (NUM_WORDS),
                .SEL_W     (SPAN_W),
                .IDX_W     (IDX_W)
            ) bank_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (kind_wr),
                .wr_bank   (slot),
                .wr_data   (reg_wdata),
                .rd_bank   (slot),
                .rd_data   (kind_rdata[k]),
                .q_idx     (kind_idx[k]),
                .q_blocked (kind_blocked[k])
            );
        end
    endgenerate

    logic       dbg_hit;
    logic       frz_hit;
    logic       frozen;

    assign dbg_hit = (word_addr == WADDR_W'(DBG_WORD));
    assign frz_hit = (word_addr == WADDR_W'(CTRL_WORD));

    dbg_enable_reg #(
        .DBG_W (DBG_W)
    ) dbg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbg_wr    (reg_wr && dbg_hit),
        .dbg_wdata (reg_wdata[DBG_W-1:0]),
        .frz_wr    (reg_wr && frz_hit),
        .frz_set   (reg_wdata[0]),
        .dbg_q     (dbg_en),
        .frozen_q  (frozen)
    );

    // Purpose: register read multiplexer; unmapped addresses read zero.
    always_comb begin
        reg_rdata = '0;
        for (int unsigned k = 0; k < NUM_KINDS; k++) begin
            if (region == REGN_W'(k)) reg_rdata = kind_rdata[k];
        end
        if (dbg_hit) reg_rdata = {{(32-DBG_W){1'b0}}, dbg_en};
        if (frz_hit) reg_rdata = {31'b0, frozen};
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (dbg_en == '0) && !frozen);
    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region >= REGN_W'(NUM_KINDS) && !dbg_hit && !frz_hit) |-> (reg_rdata == '0));
endmodule

// File: tb/fuse_lock_banks_tb.sv
// Bench: seeded random register traffic plus directed corner cases, checked
// against a reference model held in bench variables.
module fuse_lock_banks_tb_top;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NW    = 96;
    localparam int unsigned NB    = 3;
    localparam int unsigned IW    = 7;
    localparam int unsigned AW    = 8;
    localparam int unsigned DW    = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [IW-1:0] rd_idx = '0, sw_idx = '0, pg_idx = '0;
    logic          rd_blocked, sw_blocked, pg_blocked;
    logic [DW-1:0] dbg_en;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0]   m_lock [3][NB];
    logic [DW-1:0] m_dbg;
    logic          m_frz;

    always #(CLK_PERIOD/2) clk = ~clk;

    fuse_lock_banks #(.NUM_WORDS(NW), .ADDR_W(AW), .DBG_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_idx(rd_idx), .rd_blocked(rd_blocked),
        .sw_idx(sw_idx), .sw_blocked(sw_blocked),
        .pg_idx(pg_idx), .pg_blocked(pg_blocked),
        .dbg_en(dbg_en)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 3; k++)
            for (int b = 0; b < NB; b++) m_lock[k][b] = '0;
        m_dbg = '0;
        m_frz = 1'b0;
    endtask

    function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
        logic [5:0] w;
        w = a[7:2];
        if (w[5:3] < 3) return (w[2:0] < NB) ? m_lock[w[5:3]][w[2:0]] : 32'h0;
        if (w == 6'd24) return {21'b0, m_dbg};
        if (w == 6'd25) return {31'b0, m_frz};
        return 32'h0;
    endfunction

    function automatic logic exp_blk(int k, logic [IW-1:0] id);
        if (id >= NW) return 1'b1;
        return m_lock[k][id >> 5][id[4:0]];
    endfunction

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        logic [5:0] w;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        w = a[7:2];
        if (w[5:3] < 3 && w[2:0] < NB) m_lock[w[5:3]][w[2:0]] |= d;
        else if (w == 6'd24 && !m_frz) m_dbg = d[DW-1:0];
        else if (w == 6'd25 && d[0]) m_frz = 1'b1;
    endtask

    task automatic read_chk(string req, logic [AW-1:0] a);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp_rd(a));
    endtask

    task automatic gate_chk(string req, logic [IW-1:0] a, logic [IW-1:0] b, logic [IW-1:0] c);
        rd_idx = a; sw_idx = b; pg_idx = c;
        #1;
        chk({req, " refresh"}, {31'b0, rd_blocked}, {31'b0, exp_blk(0, a)});
        chk({req, " shadow"},  {31'b0, sw_blocked}, {31'b0, exp_blk(1, b)});
        chk({req, " burn"},    {31'b0, pg_blocked}, {31'b0, exp_blk(2, c)});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();

        // R1: reset state
        for (int a = 0; a < 64; a++) read_chk("R1 reset readback", AW'(a*4));
        gate_chk("R1 reset gate", 7'd0, 7'd50, 7'd95);
        chk("R1 dbg_en", {21'b0, dbg_en}, 32'h0);

        // R2 R4: id 37 -> refresh bank 1 bit 5 at 0x04
        bus_write(8'h04, 32'h0000_0020);
        read_chk("R2 bank address", 8'h04);
        gate_chk("R4 id37", 7'd37, 7'd37, 7'd37);
        gate_chk("R4 neighbour", 7'd36, 7'd5, 7'd5);
        // R3: zero write changes nothing
        bus_write(8'h04, 32'h0);
        read_chk("R3 zero write", 8'h04);
        gate_chk("R3 still set", 7'd37, 7'd0, 7'd0);
        // R5: id 70 -> shadow bank 2 bit 6 at 0x28
        bus_write(8'h28, 32'h0000_0040);
        gate_chk("R5 id70", 7'd70, 7'd70, 7'd70);
        // R6: id 95 -> burn bank 2 bit 31 at 0x48
        bus_write(8'h48, 32'h8000_0000);
        gate_chk("R6 id95", 7'd95, 7'd95, 7'd95);
        // R7: masking to 11 bits
        bus_write(8'h60, 32'hFFFF_FFFF);
        read_chk("R7 masked", 8'h60);
        chk("R7 dbg_en", {21'b0, dbg_en}, 32'h7FF);
        bus_write(8'h60, 32'hABCD_0123);
        chk("R7 dbg_en overwrite", {21'b0, dbg_en}, 32'h123);
        // R9: empty bank slot and out-of-range ids
        bus_write(8'h0C, 32'hFFFF_FFFF);
        read_chk("R9 empty slot", 8'h0C);
        gate_chk("R9 out of range", 7'd96, 7'd100, 7'd127);
        // R10: unmapped address
        bus_write(8'h70, 32'hFFFF_FFFF);
        read_chk("R10 unmapped read", 8'h70);
        read_chk("R10 state kept", 8'h60);
        read_chk("R10 freeze kept", 8'h64);

        // Random mix: writes, readbacks and gate queries (R2 R3 R4 R5 R6 R10)
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a;
            a = AW'(($urandom % 26) * 4);
            if (($urandom % 8) == 0) a = AW'(($urandom % 64) * 4);
            if (a[7:2] != 6'd25)
                bus_write(a, $urandom & $urandom & $urandom);
            read_chk("R3 random readback", AW'(($urandom % 64) * 4));
            gate_chk("R2 random gate", IW'($urandom), IW'($urandom), IW'($urandom));
        end

        // R8: freeze control
        bus_write(8'h64, 32'h0);
        read_chk("R8 zero write no freeze", 8'h64);
        bus_write(8'h60, 32'h0000_0055);
        read_chk("R8 writable before freeze", 8'h60);
        bus_write(8'h64, 32'h1);
        read_chk("R8 freeze set", 8'h64);
        bus_write(8'h60, 32'h0000_02AA);
        read_chk("R8 frozen readback", 8'h60);
        chk("R8 frozen dbg_en", {21'b0, dbg_en}, 32'h55);

        // R1: reset clears everything again
        do_reset();
        for (int a = 0; a < 26; a++) read_chk("R1 second reset", AW'(a*4));
        gate_chk("R1 second reset gate", 7'd37, 7'd70, 7'd95);

        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule